// File: doc/BRIEF.md
# SPI Serial-Flash Command Front End

This block is the slave side of a serial NOR flash command interface. After chip select falls, a host shifts in a one-byte opcode, MSB first. The block then replies with one of several fixed identification sequences, streams its status byte, or serves a sequential read from a small read-only byte array. The read address advances by itself after each byte.

The block runs on a fast system clock. It oversamples the serial clock, chip select, data in and hold pins, and treats those inputs as already synchronous to that clock. Data in is taken on rising serial-clock edges and data out moves on falling edges, so hosts that idle the clock low and hosts that idle it high are both served. A hold pin pauses a transfer without deselecting the device. Raising chip select abandons whatever command is in flight.

Top module: `spi_flash_front`

## Requirements
- R1: While cs_n is high, so_oe is low. Raising cs_n aborts any command in progress, and the next transaction starts again at the opcode byte.
- R2: Bits are taken from si on rising sclk edges and so_d changes only on falling sclk edges, whether sclk idles low or high. The opcode is received MSB first and every response byte is sent MSB first.
- R3: Opcode 0x9F answers with 0xC2, 0x20, then 0x15+DENSITY. This three-byte sequence repeats while the clock runs.
- R4: Opcode 0xAB takes three trailing bytes of any value, then answers with 0x14+DENSITY in every following byte.
- R5: Opcodes 0x90 and 0xEF take a 24-bit address, MSB first. A zero address gives 0xC2 then 0x14+DENSITY. Any nonzero address gives the same two bytes in the opposite order. The pair repeats.
- R6: Opcode 0x05 streams the status byte repeatedly. Bit 0 is the write-in-progress flag and reads 0. Bit 1 is the write-enable latch and reads 0. Bits 5:2 hold BP_INIT, with bit 2 as the lowest protect bit. Bits 7:6 read 0.
- R7: Opcode 0x03 takes a 24-bit address. The block reduces that address to its low log2(ARRAY_BYTES) bits, then returns bytes from there onward, stepping by one per byte and wrapping to 0 after ARRAY_BYTES-1. The byte at index a is ((a[7:0]*29+7) mod 256) XOR a[15:8].
- R8: While cs_n is low and hold_n is low, so_oe is low and sclk edges have no effect. Once hold_n returns high, the transfer continues exactly where it stopped.
- R9: After an unrecognized opcode, so_d stays 0 until cs_n rises. The next transaction is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause input, active low |
| so_d | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for so_d; low means high impedance |

## Verification
The bench builds the block with ARRAY_BYTES=256, DENSITY=2 and BP_INIT=4'b1011. The small array lets random reads cross the wrap from index 255 to 0 within a few bytes, and it lets the upper address bits that a read must discard take arbitrary values. DENSITY=2 moves both ID bytes away from their base values, and the asymmetric protect pattern exposes any shifted or reversed field in the status byte.

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int ARRAY_BYTES = 4096,
  parameter int DENSITY = 2,
  parameter logic [3:0] BP_INIT = 4'b0000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic si,
  input  logic hold_n,
  output logic so_d,
  output logic so_oe
);
  localparam int AW = $clog2(ARRAY_BYTES);
  localparam logic [7:0] MFR_ID = 8'hC2;
  localparam logic [7:0] MEM_TYPE = 8'h20;
  localparam logic [7:0] CAP_ID = 8'h15 + 8'(DENSITY);
  localparam logic [7:0] DEV_ID = 8'h14 + 8'(DENSITY);
  localparam logic [1:0] PH_CMD = 2'd0, PH_ADDR = 2'd1, PH_RESP = 2'd2, PH_IGN = 2'd3;

  logic        sclk_q;
  logic [1:0]  phase;
  logic [7:0]  cmd;
  logic [6:0]  rx;
  logic [2:0]  bit_cnt;
  logic [1:0]  abyte;
  logic [23:0] addr;
  logic [2:0]  tx_cnt;
  logic [1:0]  idx;
  logic        so_q;
  logic [7:0]  resp;

  wire act  = ~cs_n & hold_n;
  wire rise = act & sclk & ~sclk_q;
  wire fall = act & ~sclk & sclk_q;
  wire [7:0] rx_byte = {rx, si};

  function automatic logic [7:0] rom_byte(input logic [AW-1:0] a);
    logic [15:0] w;
    w = 16'(a);
    return 8'(w[7:0] * 8'd29 + 8'd7) ^ w[15:8];
  endfunction

  always_comb begin
    case (cmd)
      8'h9F:        resp = (idx == 2'd0) ? MFR_ID : (idx == 2'd1) ? MEM_TYPE : CAP_ID;
      8'h05:        resp = {2'b00, BP_INIT, 1'b0, 1'b0};
      8'hAB:        resp = DEV_ID;
      8'h90, 8'hEF: resp = ((addr == 24'd0) ^ idx[0]) ? MFR_ID : DEV_ID;
      8'h03:        resp = rom_byte(addr[AW-1:0]);
      default:      resp = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      phase   <= PH_CMD;
      cmd     <= 8'h00;
      rx      <= '0;
      bit_cnt <= '0;
      abyte   <= '0;
      addr    <= '0;
      tx_cnt  <= '0;
      idx     <= '0;
      so_q    <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
        abyte   <= '0;
        tx_cnt  <= '0;
        idx     <= '0;
        so_q    <= 1'b0;
      end else begin
        if (rise && (phase == PH_CMD || phase == PH_ADDR)) begin
          rx      <= {rx[5:0], si};
          bit_cnt <= bit_cnt + 3'd1;
          if (phase == PH_ADDR) addr <= {addr[22:0], si};
          if (bit_cnt == 3'd7) begin
            if (phase == PH_CMD) begin
              cmd <= rx_byte;
              case (rx_byte)
                8'h9F, 8'h05:               phase <= PH_RESP;
                8'h03, 8'h90, 8'hEF, 8'hAB: phase <= PH_ADDR;
                default:                    phase <= PH_IGN;
              endcase
            end else begin
              abyte <= abyte + 2'd1;
              if (abyte == 2'd2) phase <= PH_RESP;
            end
          end
        end
        if (fall && phase == PH_RESP) begin
          so_q   <= resp[3'd7 - tx_cnt];
          tx_cnt <= tx_cnt + 3'd1;
          if (tx_cnt == 3'd7) begin
            idx <= (cmd == 8'h9F && idx == 2'd2) ? 2'd0 : idx + 2'd1;
            if (cmd == 8'h03) addr[AW-1:0] <= addr[AW-1:0] + 1'b1;
          end
        end
      end
    end
  end

  assign so_d  = so_q;
  assign so_oe = ~cs_n & hold_n;
endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       hold_n,
  input logic       sclk,
  input logic       sclk_q,
  input logic       so_q,
  input logic [1:0] phase,
  input logic [2:0] bit_cnt,
  input logic [2:0] tx_cnt
);
  a_r1_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (phase == 2'd0 && bit_cnt == 3'd0 && tx_cnt == 3'd0 && !so_q));

  a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !hold_n) |=> ($stable(phase) && $stable(bit_cnt) && $stable(tx_cnt) && $stable(so_q)));

  a_r2_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cs_n) && !$stable(so_q)) |-> ($past(sclk_q) && !$past(sclk) && $past(hold_n)));

  a_r9_quiet_outside_response: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 2'd2) |-> (!so_q && tx_cnt == 3'd0));
endmodule

bind spi_flash_front spi_flash_front_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .sclk(sclk),
  .sclk_q(sclk_q), .so_q(so_q), .phase(phase), .bit_cnt(bit_cnt), .tx_cnt(tx_cnt)
);

// File: tb/spi_flash_front_tb_top.sv
module spi_flash_front_tb_top;
  localparam int NBYTES = 256;
  localparam int DENS = 2;
  localparam logic [3:0] BP = 4'b1011;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so_d, so_oe;
  logic mode3 = 1'b0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  spi_flash_front #(.ARRAY_BYTES(NBYTES), .DENSITY(DENS), .BP_INIT(BP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si), .hold_n(hold_n),
    .so_d(so_d), .so_oe(so_oe));

  function automatic logic [7:0] exp_rom(int a);
    int m;
    m = a % NBYTES;
    return 8'(((m & 255) * 29 + 7) & 255) ^ 8'((m >> 8) & 255);
  endfunction

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic begin_tx();
    sclk = mode3; tick(2); cs_n = 1'b0; tick(4);
  endtask

  task automatic end_tx();
    tick(4); cs_n = 1'b1; tick(4); sclk = 1'b0; tick(2);
  endtask

  task automatic xbit(input logic b, output logic o);
    if (mode3) begin sclk = 1'b0; tick(4); end
    o = so_d; si = b; tick(4);
    sclk = 1'b1; tick(4);
    if (!mode3) begin sclk = 1'b0; tick(4); end
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] o);
    logic v;
    for (int i = 7; i >= 0; i--) begin xbit(b[i], v); o[i] = v; end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d;
    xbyte(b, d);
  endtask

  task automatic send_addr(input logic [23:0] a);
    send(a[23:16]); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    logic [7:0] r, op;
    logic v;
    logic [23:0] a;
    int n;
    void'($urandom(32'd4711));
    tick(3); rst_n = 1'b1; tick(3);
    check("R1 reset so_oe", so_oe, 0);

    mode3 = 0; begin_tx(); send(8'h9F);
    for (int k = 0; k < 6; k++) begin
      xbyte(8'h00, r);
      check("R3 jedec id", r, (k % 3 == 0) ? 8'hC2 : (k % 3 == 1) ? 8'h20 : 8'h15 + 8'(DENS));
    end
    end_tx();

    mode3 = 1; begin_tx(); send(8'h9F);
    xbyte(8'h00, r); check("R2 mode3 id0", r, 8'hC2);
    xbyte(8'h00, r); check("R2 mode3 id1", r, 8'h20);
    end_tx(); mode3 = 0;

    begin_tx(); send(8'hAB); send_addr(24'($urandom));
    for (int k = 0; k < 2; k++) begin xbyte(8'h00, r); check("R4 legacy id", r, 8'h14 + 8'(DENS)); end
    end_tx();

    begin_tx(); send(8'h90); send_addr(24'h0);
    for (int k = 0; k < 4; k++) begin
      xbyte(8'h00, r); check("R5 pair zero addr", r, (k % 2 == 0) ? 8'hC2 : 8'h14 + 8'(DENS));
    end
    end_tx();
    mode3 = 1; begin_tx(); send(8'hEF); send_addr(24'h000100);
    for (int k = 0; k < 2; k++) begin
      xbyte(8'h00, r); check("R5 pair swapped", r, (k == 0) ? 8'h14 + 8'(DENS) : 8'hC2);
    end
    end_tx(); mode3 = 0;

    begin_tx(); send(8'h05);
    for (int k = 0; k < 2; k++) begin xbyte(8'h00, r); check("R6 status", r, {2'b00, BP, 2'b00}); end
    end_tx();

    begin_tx(); send(8'h03); send_addr(24'h1234FE);
    for (int k = 0; k < 4; k++) begin xbyte(8'h00, r); check("R7 read wrap", r, exp_rom(254 + k)); end
    end_tx();

    for (int it = 0; it < 20; it++) begin
      mode3 = 1'($urandom);
      a = 24'($urandom);
      n = 1 + int'($urandom % 6);
      if (it < 4) a[7:0] = 8'hFC + 8'(it);
      begin_tx(); send(8'h03); send_addr(a);
      for (int k = 0; k < n; k++) begin
        xbyte(8'h00, r); check("R7 random read", r, exp_rom(int'(a[7:0]) + k));
      end
      end_tx();
    end
    mode3 = 0;

    begin_tx(); send(8'h03); send_addr(24'h000010);
    xbyte(8'h00, r); check("R8 pre-hold byte", r, exp_rom(16));
    hold_n = 1'b0; tick(2);
    check("R8 so_oe low in hold", so_oe, 0);
    for (int k = 0; k < 3; k++) begin sclk = 1'b1; tick(4); sclk = 1'b0; tick(4); end
    hold_n = 1'b1; tick(4);
    xbyte(8'h00, r); check("R8 byte after hold", r, exp_rom(17));
    for (int i = 7; i >= 5; i--) begin xbit(1'b0, v); r[i] = v; end
    hold_n = 1'b0; tick(2);
    for (int k = 0; k < 4; k++) begin sclk = 1'b1; tick(4); sclk = 1'b0; tick(4); end
    hold_n = 1'b1; tick(4);
    for (int i = 4; i >= 0; i--) begin xbit(1'b0, v); r[i] = v; end
    check("R8 hold mid byte", r, exp_rom(18));
    end_tx();

    begin_tx(); send(8'h03); send_addr(24'h000040);
    xbyte(8'h00, r);
    for (int i = 0; i < 3; i++) xbit(1'b1, v);
    tick(2); cs_n = 1'b1; tick(4);
    check("R1 so_oe off when deselected", so_oe, 0);
    sclk = 1'b0; tick(4); cs_n = 1'b0; tick(4);
    send(8'h9F); xbyte(8'h00, r); check("R1 fresh command after abort", r, 8'hC2);
    end_tx();

    for (int it = 0; it < 3; it++) begin
      do op = 8'($urandom);
      while (op == 8'h9F || op == 8'h05 || op == 8'h03 || op == 8'h90 || op == 8'hEF || op == 8'hAB);
      begin_tx(); send(op);
      for (int k = 0; k < 3; k++) begin xbyte(8'hFF, r); check("R9 unknown opcode quiet", r, 8'h00); end
      end_tx();
      begin_tx(); send(8'h05); xbyte(8'h00, r); check("R9 next tx ok", r, {2'b00, BP, 2'b00});
      end_tx();
    end

    report();
  end
endmodule